// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is an I2C target that lets an external host reach a bank of 8-bit registers held outside the block. It samples SCL and SDA on the system clock through two-flop synchronizers. It finds start, repeated-start and stop conditions from those samples and decodes the bit stream. It only ever pulls SDA low, through an output enable, and an external pull-up is assumed.

A write transaction carries the device address, then one pointer byte, then optional data bytes. Every data byte is offered on a one-cycle write strobe for the register the pointer selects. The pointer never advances. A read transaction returns exactly one byte, taken from the register that the current pointer selects. The read request strobe tells the register bank which register is wanted. The read data is sampled when the slave starts to shift it out.

The 7-bit device address comes from a configuration-pin input. It follows the pin until the device has been addressed successfully twice. It is then frozen for good.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After a start condition, the first byte is the 7-bit address, MSB first, followed by a direction bit (0 = host writes, 1 = host reads). Only a matching address is acknowledged, by holding SDA low through the ninth SCL pulse. After a mismatch, SDA is never driven and no strobe fires until the next start.
- R2: A write that carries only the pointer byte loads `reg_ptr` with that byte and produces no write strobe.
- R3: In a write, the byte after the pointer produces one single-cycle `wr_en` pulse. During that pulse, `wr_data` holds the byte and `reg_ptr` holds the pointer. Every byte of a matched write is acknowledged.
- R4: Further data bytes in the same write each produce another `wr_en` pulse to the same register. `reg_ptr` does not change, and neighbouring registers are untouched.
- R5: A read produces one single-cycle `rd_req` pulse and then sends `rd_data` for the current `reg_ptr`, MSB first. `reg_ptr` is unchanged. After that one byte, the slave leaves SDA released even if the host acknowledges, so any further byte reads as 0xFF.
- R6: Before the address is frozen, matching uses the present value of `addr_pin`. The address is captured on the second successful addressing. From then on, changes on `addr_pin` have no effect.
- R7: A stop, or a repeated start, at any point releases SDA and returns the slave to address reception. A byte cut short this way causes no write.
- R8: While reset is held, `sda_oe`, `wr_en` and `rd_req` are 0 and `reg_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| addr_pin | input | AW | Device address decoded from the configuration pin |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| reg_ptr | output | DW | Current register pointer |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_data | output | DW | Data for the register write |
| rd_req | output | 1 | One-cycle read request for the register at `reg_ptr` |
| rd_data | input | DW | Contents of the register at `reg_ptr` |

## Verification
The hardest case to reach from the ports is the moment the device address freezes. It depends on how many successful addressings came before, and not on time. The bench first moves `addr_pin` before any addressing. It then sweeps every address once, so that exactly one addressing matches. The next pointer write is the second match, and after it the bench changes the pin and probes both the old and the new address. Aborted bytes are produced by issuing a repeated start or a stop after only a few data bits. The bench then checks that no write occurred and that the next transaction is decoded normally.

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW-1:0] addr_pin,
  output logic          sda_oe,
  output logic [DW-1:0] reg_ptr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  input  logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl, sda, rise, fall, start_c, stop_c;

  st_t          st;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh;
  logic [1:0]    nbyte;
  logic          rnw, seen, locked;
  logic [AW-1:0] addr_q, match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl     = scl_sy[1];
  assign sda     = sda_sy[1];
  assign rise    = scl & ~scl_d;
  assign fall    = ~scl & scl_d;
  assign start_c = scl & scl_d & sda_d & ~sda;
  assign stop_c  = scl & scl_d & ~sda_d & sda;
  assign match   = locked ? addr_q : addr_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      nbyte   <= '0;
      rnw     <= 1'b0;
      seen    <= 1'b0;
      locked  <= 1'b0;
      addr_q  <= '0;
      reg_ptr <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      rd_req  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      if (start_c) begin
        st     <= S_RX;
        bitcnt <= '0;
        nbyte  <= '0;
        rnw    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (rise) begin
              sh     <= {sh[DW-2:0], sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (fall && bitcnt == CW'(DW)) begin
              bitcnt <= '0;
              if (nbyte == 2'd0) begin
                if (sh[DW-1 -: AW] == match) begin
                  st     <= S_ACK;
                  sda_oe <= 1'b1;
                  rnw    <= sh[0];
                  rd_req <= sh[0];
                  nbyte  <= 2'd1;
                  if (!locked) begin
                    if (seen) begin
                      locked <= 1'b1;
                      addr_q <= addr_pin;
                    end else begin
                      seen <= 1'b1;
                    end
                  end
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st     <= S_ACK;
                sda_oe <= 1'b1;
                if (nbyte == 2'd1) begin
                  reg_ptr <= sh;
                  nbyte   <= 2'd2;
                end else begin
                  wr_en   <= 1'b1;
                  wr_data <= sh;
                end
              end
            end
          end
          S_ACK: begin
            if (fall) begin
              bitcnt <= '0;
              if (rnw) begin
                st     <= S_TX;
                sh     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (fall) begin
              if (bitcnt == CW'(DW - 1)) begin
                st     <= S_MACK;
                sda_oe <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
              end
            end
          end
          S_MACK: begin
            if (rise) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_slave_sva.sv
module i2c_ptr_slave_sva #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          wr_en,
  input logic          rd_req,
  input logic [DW-1:0] reg_ptr,
  input logic          start_c,
  input logic          stop_c,
  input logic          locked
);
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r4_ptr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(reg_ptr));

  a_r5_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $stable(reg_ptr));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !sda_oe);

  a_r6_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req));
endmodule

bind i2c_ptr_slave i2c_ptr_slave_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_en(wr_en),
  .rd_req(rd_req), .reg_ptr(reg_ptr), .start_c(start_c),
  .stop_c(stop_c), .locked(locked)
);

// File: tb/i2c_ptr_slave_bench.sv
module i2c_ptr_slave_bench;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h48;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] addr_pin = 7'h30;
  logic       sda_oe, wr_en, rd_req;
  logic [7:0] reg_ptr, wr_data, rd_data;
  wire        sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [0:255];
  logic [7:0] expv [0:255];
  int wr_cnt = 0, rd_cnt = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  assign rd_data = mem[reg_ptr];

  i2c_ptr_slave u_i2c_ptr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pin(addr_pin), .sda_oe(sda_oe), .reg_ptr(reg_ptr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (wr_en) begin
      mem[reg_ptr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rd_req) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic hw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw();
    scl_m = 1'b1; hw();
    sda_m = 1'b0; hw();
    scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw();
    scl_m = 1'b1; hw();
    sda_m = 1'b1; hw();
  endtask

  task automatic sbit(input bit b);
    sda_m = b; hw();
    scl_m = 1'b1; hw();
    scl_m = 1'b0; hw();
  endtask

  task automatic rbit(output bit b);
    sda_m = 1'b1; hw();
    scl_m = 1'b1;
    repeat (Q/2) @(posedge clk);
    #1;
    b = sda_bus;
    repeat (Q - Q/2) @(posedge clk);
    #1;
    scl_m = 1'b0; hw();
  endtask

  task automatic sbyte(input logic [7:0] v, output bit nak);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
    rbit(nak);
  endtask

  task automatic rbyte(output logic [7:0] v, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      bit b;
      rbit(b);
      v[i] = b;
    end
    sbit(mack);
  endtask

  task automatic set_ptr(input logic [7:0] p, output bit nak);
    bit n0, n1;
    bus_start();
    sbyte({OWN, 1'b0}, n0);
    sbyte(p, n1);
    bus_stop();
    nak = n0 | n1;
  endtask

  task automatic read_one(output logic [7:0] v, output bit nak);
    bus_start();
    sbyte({OWN, 1'b1}, nak);
    rbyte(v, 1'b1);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit n0, n1, n2, n3;
    logic [7:0] v0, v1;
    int base, rbase;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      expv[i] = 8'h00;
    end
    repeat (4) @(posedge clk);
    #1;
    chk(sda_oe == 0 && wr_en == 0 && rd_req == 0, "R8 outputs idle in reset", sda_oe, 0);
    chk(reg_ptr == 0, "R8 pointer zero in reset", reg_ptr, 0);
    rst_n = 1'b1;
    hw();

    addr_pin = OWN;
    hw();
    for (int a = 0; a < 128; a++) begin
      bus_start();
      sbyte({a[6:0], 1'b0}, n0);
      bus_stop();
      chk(n0 == (a != OWN), "R1/R6 address sweep ack", {a[7:0], 7'd0, n0}, a != OWN);
    end

    base = wr_cnt;
    set_ptr(8'h05, n0);
    chk(!n0, "R2 pointer write acked", n0, 0);
    chk(reg_ptr == 8'h05, "R2 pointer loaded", reg_ptr, 8'h05);
    chk(wr_cnt == base, "R2 no write strobe", wr_cnt, base);

    addr_pin = 7'h21;
    hw();
    bus_start();
    sbyte({7'h21, 1'b0}, n0);
    sbyte(8'h02, n1);
    sbyte(8'h77, n2);
    bus_stop();
    chk(n0 && n1 && n2, "R6 new pin value ignored", {n0, n1, n2}, 3'b111);
    chk(wr_cnt == base && reg_ptr == 8'h05, "R1 unmatched transaction inert", reg_ptr, 8'h05);
    bus_start();
    sbyte({OWN, 1'b0}, n0);
    bus_stop();
    chk(!n0, "R6 frozen address still acked", n0, 0);

    for (int p = 0; p < 16; p++) begin
      logic [7:0] d;
      d = 8'((p * 37 + 11) & 255);
      base = wr_cnt;
      bus_start();
      sbyte({OWN, 1'b0}, n0);
      sbyte(p[7:0], n1);
      sbyte(d, n2);
      bus_stop();
      expv[p] = d;
      chk(!n0 && !n1 && !n2, "R3 all bytes acked", {n0, n1, n2}, 0);
      chk(wr_cnt == base + 1, "R3 single write strobe", wr_cnt - base, 1);
      chk(reg_ptr == p[7:0], "R3 pointer selects register", reg_ptr, p);
    end

    for (int p = 15; p >= 0; p--) begin
      base = wr_cnt;
      rbase = rd_cnt;
      set_ptr(p[7:0], n0);
      chk(wr_cnt == base && reg_ptr == p[7:0], "R2 pointer-only write", reg_ptr, p);
      read_one(v0, n1);
      chk(!n1 && v0 == expv[p], "R5 read returns register", v0, expv[p]);
      chk(rd_cnt == rbase + 1 && reg_ptr == p[7:0], "R5 one request, pointer kept", rd_cnt - rbase, 1);
    end

    base = wr_cnt;
    bus_start();
    sbyte({OWN, 1'b0}, n0);
    sbyte(8'h03, n1);
    sbyte(8'hA1, n2);
    sbyte(8'hB2, n3);
    sbyte(8'hC3, n3);
    bus_stop();
    expv[3] = 8'hC3;
    chk(wr_cnt == base + 3, "R4 three strobes", wr_cnt - base, 3);
    chk(reg_ptr == 8'h03, "R4 pointer not advanced", reg_ptr, 3);
    bus_start();
    sbyte({OWN, 1'b1}, n0);
    rbyte(v0, 1'b0);
    rbyte(v1, 1'b1);
    bus_stop();
    chk(v0 == 8'hC3, "R4 last byte kept", v0, 8'hC3);
    chk(v1 == 8'hFF, "R5 only one byte driven", v1, 8'hFF);
    set_ptr(8'h04, n0);
    read_one(v0, n1);
    chk(v0 == expv[4], "R4 neighbour untouched", v0, expv[4]);

    base = wr_cnt;
    bus_start();
    sbyte({OWN, 1'b0}, n0);
    sbyte(8'h07, n1);
    sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1);
    bus_start();
    sbyte({OWN, 1'b1}, n2);
    rbyte(v0, 1'b1);
    bus_stop();
    chk(!n2 && v0 == expv[7], "R7 repeated start aborts byte", v0, expv[7]);
    chk(wr_cnt == base && reg_ptr == 8'h07, "R7 no write after abort", wr_cnt - base, 0);

    bus_start();
    sbyte({OWN, 1'b0}, n0);
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    bus_stop();
    chk(wr_cnt == base && reg_ptr == 8'h07 && sda_oe == 0, "R7 stop mid-byte", reg_ptr, 7);
    read_one(v0, n1);
    chk(!n1 && v0 == expv[7], "R7 next transaction decoded", v0, expv[7]);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule